// File: doc/BRIEF.md
# Monitor Transmit Interrupt Status Register

This block gathers transmit-side events from sixteen serial monitor channels into one 16-bit sticky status word. The channels form two time-division multiplexes of eight channels each. A channel's bit latches high when any of three things happens on that channel:

- the channel finishes sending a word and that word is pre-acknowledged, which frees its data holding register for the next word;
- the far-end receiver aborts the message;
- a 1 ms timeout fires while the global timeout-enable control is set.

Software reads the word through a single read strobe. The read returns the current contents and then clears every bit. A summary interrupt line is high whenever any bit is set, unless a mask input holds it low. The mask never changes the status bits.

An event that arrives in the same clock cycle as the clearing read is kept. The read clears only the bits it has already reported, so an event can never fall in the gap between a read and its clear.

Top module: `txmon_irq_status`

## Requirements
- R1: After reset `rd_data_o` reads 0x0000 and `irq_o` is 0.
- R2: Channel x (0..7) of multiplex 0 owns bit x of `rd_data_o`, and channel x of multiplex 1 owns bit 8+x.
- R3: A one-cycle pulse on a channel's word-done input sets that channel's bit from the next cycle. The bit stays set until a read, and no other bit changes.
- R4: A one-cycle pulse on a channel's abort input sets that channel's bit from the next cycle.
- R5: A timeout pulse sets the channel's bit only while `tmo_en_i` is 1. While `tmo_en_i` is 0, a timeout pulse leaves `rd_data_o` unchanged.
- R6: In a cycle with `rd_stb_i` high, `rd_data_o` shows the contents from before the clear. In the following cycle every bit is 0, unless an event arrived during the read cycle.
- R7: A set event that arrives in the same cycle as `rd_stb_i` leaves its bit at 1 after the read.
- R8: `irq_o` is 1 exactly when `rd_data_o` is non-zero and `irq_mask_i` is 0.
- R9: While `irq_mask_i` is 1, `irq_o` stays 0 and the status bits still set and clear as in R3 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| word_done_m0_i | input | 8 | Word sent and pre-acknowledged, multiplex 0 channels |
| word_done_m1_i | input | 8 | Word sent and pre-acknowledged, multiplex 1 channels |
| abort_m0_i | input | 8 | Remote abort, multiplex 0 channels |
| abort_m1_i | input | 8 | Remote abort, multiplex 1 channels |
| tmo_m0_i | input | 8 | 1 ms timeout, multiplex 0 channels |
| tmo_m1_i | input | 8 | 1 ms timeout, multiplex 1 channels |
| tmo_en_i | input | 1 | Lets timeout pulses set status bits |
| rd_stb_i | input | 1 | Processor read strobe; clears the register |
| irq_mask_i | input | 1 | 1 holds the summary interrupt low |
| rd_data_o | output | 16 | Current status word |
| irq_o | output | 1 | Summary transmit interrupt |

## Verification
The cycle that matters most is the one where a clearing read and a new set event land together. The bench builds this case on purpose. It loads some bits, then raises `rd_stb_i` in the same cycle as a word-done, abort or enabled-timeout pulse on a channel that is still clear. The bench checks that the read cycle returns the old contents. It then checks that, one cycle later, only the newly hit channel remains set. It runs a second version of this case where the event hits a bit that was already set. There, the read must still report the bit and the bit must survive the clear.

// File: rtl/txmon_pkg.sv
package txmon_pkg;
    parameter int CH_PER_MUX = 8;
    parameter int NUM_MUX    = 2;
    localparam int NUM_CH    = CH_PER_MUX * NUM_MUX;

    typedef logic [NUM_CH-1:0] stat_vec_t;
    typedef logic [NUM_MUX-1:0][CH_PER_MUX-1:0] mux_vec_t;

    typedef struct packed {
        stat_vec_t status;
    } stat_state_t;
endpackage

// File: rtl/txmon_evt_merge.sv
module txmon_evt_merge
    import txmon_pkg::*;
(
    input  mux_vec_t  done_i,
    input  mux_vec_t  abort_i,
    input  mux_vec_t  tmo_i,
    input  logic      tmo_en_i,
    output stat_vec_t set_o
);
    // Each multiplex fills a contiguous slice of the status word.
    // Channel x of multiplex m lands on bit m*CH_PER_MUX + x.
    for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
        for (genvar c = 0; c < CH_PER_MUX; c++) begin : g_ch
            always_comb begin
                set_o[m*CH_PER_MUX + c] = done_i[m][c] | abort_i[m][c]
                                          | (tmo_i[m][c] & tmo_en_i);
            end
        end
    end
endmodule

// File: rtl/txmon_stat_reg.sv
module txmon_stat_reg
    import txmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  stat_vec_t set_i,
    input  logic      rd_stb_i,
    output stat_vec_t status_o
);
    stat_state_t st_d, st_q;

    // A read clears only the bits it has already reported.
    // Events that arrive in the read cycle are kept.
    always_comb begin
        st_d = st_q;
        if (rd_stb_i) begin
            st_d.status = '0;
        end
        st_d.status = st_d.status | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && set_i == '0) |=> status_o == '0); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> (status_o & $past(status_o)) == $past(status_o)); // R3

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o & $past(set_i)) == $past(set_i)); // R7
endmodule

// File: rtl/txmon_irq_sum.sv
module txmon_irq_sum
    import txmon_pkg::*;
(
    input  stat_vec_t status_i,
    input  logic      mask_i,
    output logic      irq_o
);
    always_comb begin
        irq_o = (|status_i) & ~mask_i;
    end
endmodule

// File: rtl/txmon_irq_status.sv
module txmon_irq_status
    import txmon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  word_done_m0_i,
    input  logic [7:0]  word_done_m1_i,
    input  logic [7:0]  abort_m0_i,
    input  logic [7:0]  abort_m1_i,
    input  logic [7:0]  tmo_m0_i,
    input  logic [7:0]  tmo_m1_i,
    input  logic        tmo_en_i,
    input  logic        rd_stb_i,
    input  logic        irq_mask_i,
    output logic [15:0] rd_data_o,
    output logic        irq_o
);
    mux_vec_t  done_v, abort_v, tmo_v;
    stat_vec_t set_w, status_w;

    assign done_v  = {word_done_m1_i, word_done_m0_i};
    assign abort_v = {abort_m1_i, abort_m0_i};
    assign tmo_v   = {tmo_m1_i, tmo_m0_i};

    txmon_evt_merge u_merge (
        .done_i   (done_v),
        .abort_i  (abort_v),
        .tmo_i    (tmo_v),
        .tmo_en_i (tmo_en_i),
        .set_o    (set_w)
    );

    txmon_stat_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .rd_stb_i (rd_stb_i),
        .status_o (status_w)
    );

    txmon_irq_sum u_sum (
        .status_i (status_w),
        .mask_i   (irq_mask_i),
        .irq_o    (irq_o)
    );

    assign rd_data_o = status_w;

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((rd_data_o != 16'h0) && !irq_mask_i)); // R8

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask_i |-> !irq_o); // R9

    AST_TMO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmo_en_i && word_done_m0_i == 8'h0 && word_done_m1_i == 8'h0
         && abort_m0_i == 8'h0 && abort_m1_i == 8'h0)
        |=> rd_data_o == ($past(rd_stb_i) ? 16'h0 : $past(rd_data_o))); // R5
endmodule

// File: tb/tb_txmon_irq_status.sv
module tb_txmon_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  wd0 = '0, wd1 = '0, ab0 = '0, ab1 = '0, to0 = '0, to1 = '0;
    logic        tmo_en = 1'b0, rd_stb = 1'b0, mask = 1'b0;
    logic [15:0] rd_data;
    logic        irq;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    txmon_irq_status dut (
        .clk(clk), .rst_n(rst_n),
        .word_done_m0_i(wd0), .word_done_m1_i(wd1),
        .abort_m0_i(ab0), .abort_m1_i(ab1),
        .tmo_m0_i(to0), .tmo_m1_i(to1),
        .tmo_en_i(tmo_en), .rd_stb_i(rd_stb), .irq_mask_i(mask),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of events (low byte = multiplex 0) with optional read,
    // starting at a negedge; returns at the next negedge with inputs idle.
    task automatic cyc(input logic [15:0] d, input logic [15:0] a,
                       input logic [15:0] t, input logic rd);
        {wd1, wd0} = d; {ab1, ab0} = a; {to1, to0} = t; rd_stb = rd;
        @(negedge clk);
        {wd1, wd0} = '0; {ab1, ab0} = '0; {to1, to0} = '0; rd_stb = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [15:0] exp_before);
        rd_stb = 1'b1;
        #1 check(req, rd_data, exp_before);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 status", rd_data, 16'h0000);
        check("R1 irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_placement;
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 8; c++) begin
                logic [15:0] bitv = 16'h1 << (m*8 + c);
                cyc(bitv, 16'h0, 16'h0, 1'b0);
                check("R2/R3 bit position", rd_data, bitv);
                do_read("R6 read value", bitv);
                check("R6 cleared", rd_data, 16'h0);
            end
        end
    endtask

    task automatic t_sticky;
        cyc(16'h0004, 16'h0, 16'h0, 1'b0);
        repeat (3) @(negedge clk);
        check("R3 sticky", rd_data, 16'h0004);
        cyc(16'h0200, 16'h0, 16'h0, 1'b0);
        check("R3 accumulate", rd_data, 16'h0204);
        do_read("R6 read value", 16'h0204);
        check("R6 cleared", rd_data, 16'h0);
    endtask

    task automatic t_abort;
        cyc(16'h0, 16'h8001, 16'h0, 1'b0);
        check("R4 abort sets", rd_data, 16'h8001);
        do_read("R6 read value", 16'h8001);
        check("R6 cleared", rd_data, 16'h0);
    endtask

    task automatic t_timeout;
        tmo_en = 1'b0;
        cyc(16'h0, 16'h0, 16'h0410, 1'b0);
        check("R5 timeout ignored when disabled", rd_data, 16'h0);
        tmo_en = 1'b1;
        cyc(16'h0, 16'h0, 16'h0410, 1'b0);
        check("R5 timeout sets when enabled", rd_data, 16'h0410);
        tmo_en = 1'b0;
        do_read("R6 read value", 16'h0410);
        check("R6 cleared", rd_data, 16'h0);
    endtask

    task automatic t_collide;
        cyc(16'h0001, 16'h0, 16'h0, 1'b0);
        #1 check("R6 pre-read", rd_data, 16'h0001);
        cyc(16'h0100, 16'h0020, 16'h0, 1'b1);
        check("R7 event during read kept", rd_data, 16'h0120);
        cyc(16'h0, 16'h0, 16'h0, 1'b0);
        check("R7 held", rd_data, 16'h0120);
        cyc(16'h0020, 16'h0, 16'h0, 1'b1);
        check("R7 same bit survives read", rd_data, 16'h0020);
        tmo_en = 1'b1;
        cyc(16'h0, 16'h0, 16'h4000, 1'b1);
        tmo_en = 1'b0;
        check("R7 enabled timeout during read", rd_data, 16'h4000);
        do_read("R6 read value", 16'h4000);
        check("R6 cleared", rd_data, 16'h0);
    endtask

    task automatic t_irq_mask;
        check("R8 idle irq", {15'h0, irq}, 16'h0);
        cyc(16'h0800, 16'h0, 16'h0, 1'b0);
        check("R8 irq high", {15'h0, irq}, 16'h1);
        mask = 1'b1;
        #1 check("R9 irq masked", {15'h0, irq}, 16'h0);
        cyc(16'h0002, 16'h0, 16'h0, 1'b0);
        check("R9 status still sets", rd_data, 16'h0802);
        mask = 1'b0;
        #1 check("R8 irq after unmask", {15'h0, irq}, 16'h1);
        do_read("R6 read value", 16'h0802);
        check("R8 irq low after clear", {15'h0, irq}, 16'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_placement();
                t_sticky();
                t_abort();
                t_timeout();
                t_collide();
                t_irq_mask();
            end
            begin
                repeat (5000) @(negedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule